// File: doc/BRIEF.md
# PLL Clock Control Sequencer

This block holds the configuration and status state of a PLL-based clock generator and enforces the ordering rules for changing it. Software writes two registers over a small write port. A write takes effect only while a protect-enable input is high. The multiplier register holds a 4-bit code. The divider register holds a 2-bit post-divide select and a power-down request bit. The analog PLL reports lock on one input. From that input the block keeps a sticky lock-status bit, and it decides whether the core clock runs from the multiplied clock or bypasses the PLL.

Every accepted change of the multiplier drops the lock status, which forces bypass until the PLL reports lock again. The post-divider may change only in a safe state, and divide-by-one is allowed only while the PLL output is not in use. The block also reports the effective core-clock ratio against the input clock as a numerator and denominator. An external reset or a watchdog reset clears the configuration. A debugger reset or a missing-clock reset clears only the error flag.

Top module: `pll_clk_seq`

## Requirements
- R1: While `ext_rst_n` is low or `wdog_rst` is high, the next edge gives multiplier 0, divide select 0, off 0, lock status 0 and error 0. The outputs are then bypass 1, ratio 1/4 and `pll_off` 0.
- R2: `dbg_rst` or `mclk_rst` leaves the multiplier, divide select, off bit and lock status unchanged, and clears `cfg_err` at the next edge.
- R3: A write with `wr_prot` low changes no register and no flag.
- R4: A multiplier write (`wr_sel`=0, code in `wr_data[3:0]`) of a code from 0 to 10 is stored only when the divide select is 0 and the PLL is not off. In every other case it is ignored.
- R5: A multiplier write of a code from 11 to 15 that would otherwise be accepted leaves the multiplier unchanged and sets the sticky `cfg_err`.
- R6: An accepted multiplier write clears `lock_sts` at that edge. Otherwise `lock_sts` sets at the first edge where `pll_lock` is high and stays set. It is held at 0 while off.
- R7: `pll_bypass` is 1 when the multiplier is 0, lock status is 0, or off is set. `core_num` equals the multiplier when not bypassed and 1 when bypassed.
- R8: A divider write (`wr_sel`=1, select in `wr_data[1:0]`) updates the divide select only when lock status is 1 or off is set. `core_den` is 4 for selects 0 and 1, 2 for select 2, and 1 for select 3.
- R9: Divide select 3 is accepted only when the multiplier is 0 or the PLL is off.
- R10: In a divider write, `wr_data[2]`=1 sets off only when the multiplier is 0, and `wr_data[2]`=0 clears off. `pll_off` shows the off bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, active low, synchronous |
| wdog_rst | input | 1 | Watchdog reset, active high |
| dbg_rst | input | 1 | Debugger reset, active high (clears error only) |
| mclk_rst | input | 1 | Missing-clock reset, active high (clears error only) |
| wr_en | input | 1 | Write strobe |
| wr_prot | input | 1 | Protected-write enable |
| wr_sel | input | 1 | 0 = multiplier register, 1 = divider register |
| wr_data | input | 4 | Write data |
| pll_lock | input | 1 | Lock indication from the analog PLL |
| mult_code | output | 4 | Stored multiplier code |
| div_sel | output | 2 | Stored post-divide select |
| pll_bypass | output | 1 | Core clock bypasses the PLL |
| pll_off | output | 1 | PLL power-down |
| core_num | output | 4 | Core clock ratio numerator |
| core_den | output | 3 | Core clock ratio denominator |
| lock_sts | output | 1 | Sticky lock status |
| cfg_err | output | 1 | Sticky reserved-code error |

## Verification
Every register result is due at the first rising edge after a write, reset or lock stimulus. `core_num`, `core_den` and `pll_bypass` are combinational from those registers, so they change at the same edge. The bench applies each stimulus just after an edge and compares all outputs 2 ns after the next edge against a model built from the requirements. A lock arriving in the cycle after a multiplier write shows in `lock_sts` one edge later, and the bench samples it at that edge.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
   localparam int DIV_W  = 2;
   localparam int DEN_W  = 3;
   localparam logic [DIV_W-1:0] DIV_BY_ONE = 2'd3;

   function automatic logic [DEN_W-1:0] den_of(input logic [DIV_W-1:0] sel);
      logic [DEN_W-1:0] d;
      if (sel == 2'd3)      d = 3'd1;
      else if (sel == 2'd2) d = 3'd2;
      else                  d = 3'd4;
      return d;
   endfunction
endpackage

// File: rtl/pllseq_mult_reg.sv
module pllseq_mult_reg #(
   parameter int MULT_W   = 4,
   parameter int MULT_MAX = 10
) (
   input  logic              clk,
   input  logic              hard_rst,
   input  logic              soft_rst,
   input  logic              wr_req,
   input  logic [MULT_W-1:0] wr_code,
   input  logic              div_is_zero,
   input  logic              off_q,
   input  logic              lock_in,
   output logic [MULT_W-1:0] mult_q,
   output logic              lock_q,
   output logic              err_q,
   output logic              take
);
   logic gate, code_ok, bad;

   assign gate    = wr_req & div_is_zero & ~off_q;
   assign code_ok = (wr_code <= MULT_W'(MULT_MAX));
   assign take    = gate & code_ok;
   assign bad     = gate & ~code_ok;

   always_ff @(posedge clk) begin
      if (hard_rst) begin
         mult_q <= '0;
         lock_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (take) mult_q <= wr_code;
         if (take)         lock_q <= 1'b0;
         else if (off_q)   lock_q <= 1'b0;
         else if (lock_in) lock_q <= 1'b1;
         if (soft_rst) err_q <= 1'b0;
         else if (bad) err_q <= 1'b1;
      end
   end

   // R4: multiplier moves only on an accepted write
   assert_mult_hold_R4: assert property (@(posedge clk) disable iff (hard_rst)
      !take |=> $stable(mult_q));
   // R6: accepted write drops lock status
   assert_lock_drop_R6: assert property (@(posedge clk) disable iff (hard_rst)
      take |=> !lock_q);
   // R5: stored code never reserved
   assert_no_reserved_R5: assert property (@(posedge clk) disable iff (hard_rst)
      mult_q <= MULT_W'(MULT_MAX));
endmodule

// File: rtl/pllseq_div_reg.sv
module pllseq_div_reg
   import pllseq_pkg::*;
(
   input  logic             clk,
   input  logic             hard_rst,
   input  logic             wr_req,
   input  logic [DIV_W-1:0] wr_div,
   input  logic             wr_off,
   input  logic             lock_q,
   input  logic             mult_zero,
   output logic [DIV_W-1:0] div_q,
   output logic             off_q
);
   logic safe_state, one_ok, div_ok;

   assign safe_state = lock_q | off_q;
   assign one_ok     = (wr_div != DIV_BY_ONE) | mult_zero | off_q;
   assign div_ok     = wr_req & safe_state & one_ok;

   always_ff @(posedge clk) begin
      if (hard_rst) begin
         div_q <= '0;
         off_q <= 1'b0;
      end else begin
         if (div_ok) div_q <= wr_div;
         if (wr_req) begin
            if (!wr_off)        off_q <= 1'b0;
            else if (mult_zero) off_q <= 1'b1;
         end
      end
   end

   // R10: off only with zero multiplier
   assert_off_zero_mult_R10: assert property (@(posedge clk) disable iff (hard_rst)
      off_q |-> mult_zero);
   // R8: divider holds without a write
   assert_div_hold_R8: assert property (@(posedge clk) disable iff (hard_rst)
      !wr_req |=> $stable(div_q));
endmodule

// File: rtl/pllseq_ratio.sv
module pllseq_ratio
   import pllseq_pkg::*;
#(
   parameter int MULT_W = 4
) (
   input  logic              bypass,
   input  logic [MULT_W-1:0] mult_q,
   input  logic [DIV_W-1:0]  div_q,
   output logic [MULT_W-1:0] num,
   output logic [DEN_W-1:0]  den
);
   always_comb begin
      num = bypass ? MULT_W'(1) : mult_q;
      den = den_of(div_q);
   end

   // R7: numerator is 1 in bypass
   always_comb assert_num_bypass_R7: assert (!bypass || num == MULT_W'(1));
endmodule

// File: rtl/pll_clk_seq.sv
module pll_clk_seq
   import pllseq_pkg::*;
#(
   parameter int MULT_W   = 4,
   parameter int MULT_MAX = 10,
   parameter int DATA_W   = 4
) (
   input  logic              clk,
   input  logic              ext_rst_n,
   input  logic              wdog_rst,
   input  logic              dbg_rst,
   input  logic              mclk_rst,
   input  logic              wr_en,
   input  logic              wr_prot,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pll_lock,
   output logic [MULT_W-1:0] mult_code,
   output logic [DIV_W-1:0]  div_sel,
   output logic              pll_bypass,
   output logic              pll_off,
   output logic [MULT_W-1:0] core_num,
   output logic [DEN_W-1:0]  core_den,
   output logic              lock_sts,
   output logic              cfg_err
);
   generate
      if (MULT_MAX >= (1 << MULT_W)) begin : g_bad_max
         $error("MULT_MAX does not fit MULT_W");
      end
      if (DATA_W != MULT_W || DATA_W < DIV_W + 1) begin : g_bad_data
         $error("DATA_W must equal MULT_W and hold divider fields");
      end
   endgenerate

   logic hard_rst, soft_rst, wr_ok, mult_take;
   logic [MULT_W-1:0] mult_q;
   logic [DIV_W-1:0]  div_q;
   logic lock_q, off_q, err_q, byp;

   assign hard_rst = ~ext_rst_n | wdog_rst;
   assign soft_rst = dbg_rst | mclk_rst;
   assign wr_ok    = wr_en & wr_prot;

   pllseq_mult_reg #(.MULT_W(MULT_W), .MULT_MAX(MULT_MAX)) u_mult (
      .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
      .wr_req(wr_ok & ~wr_sel), .wr_code(wr_data[MULT_W-1:0]),
      .div_is_zero(div_q == '0), .off_q(off_q), .lock_in(pll_lock),
      .mult_q(mult_q), .lock_q(lock_q), .err_q(err_q), .take(mult_take)
   );

   pllseq_div_reg u_div (
      .clk(clk), .hard_rst(hard_rst), .wr_req(wr_ok & wr_sel),
      .wr_div(wr_data[DIV_W-1:0]), .wr_off(wr_data[DIV_W]),
      .lock_q(lock_q), .mult_zero(mult_q == '0),
      .div_q(div_q), .off_q(off_q)
   );

   assign byp = (mult_q == '0) | ~lock_q | off_q;

   pllseq_ratio #(.MULT_W(MULT_W)) u_ratio (
      .bypass(byp), .mult_q(mult_q), .div_q(div_q),
      .num(core_num), .den(core_den)
   );

   assign mult_code  = mult_q;
   assign div_sel    = div_q;
   assign pll_bypass = byp;
   assign pll_off    = off_q;
   assign lock_sts   = lock_q;
   assign cfg_err    = err_q;

   // R9: divide by one never with the PLL clock in use
   assert_div1_bypass_R9: assert property (@(posedge clk) disable iff (hard_rst)
      (div_q == DIV_BY_ONE) |-> byp);
   // R3: unprotected write changes nothing
   assert_prot_R3: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
      (wr_en && !wr_prot && !mult_take) |=> ($stable(div_q) && $stable(off_q) && $stable(mult_q)));
   // R2: soft reset clears error
   assert_soft_err_R2: assert property (@(posedge clk) disable iff (hard_rst)
      soft_rst |=> !err_q);
endmodule

// File: tb/pll_clk_seq_bench.sv
module pll_clk_seq_bench;
   logic clk = 0;
   logic ext_rst_n, wdog_rst, dbg_rst, mclk_rst;
   logic wr_en, wr_prot, wr_sel, pll_lock;
   logic [3:0] wr_data;
   logic [3:0] mult_code, core_num;
   logic [1:0] div_sel;
   logic [2:0] core_den;
   logic pll_bypass, pll_off, lock_sts, cfg_err;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [3:0] e_mult; logic [1:0] e_div; logic e_off, e_lock, e_err;

   always #4 clk = ~clk;

   pll_clk_seq u_pll_clk_seq (
      .clk(clk), .ext_rst_n(ext_rst_n), .wdog_rst(wdog_rst), .dbg_rst(dbg_rst),
      .mclk_rst(mclk_rst), .wr_en(wr_en), .wr_prot(wr_prot), .wr_sel(wr_sel),
      .wr_data(wr_data), .pll_lock(pll_lock), .mult_code(mult_code),
      .div_sel(div_sel), .pll_bypass(pll_bypass), .pll_off(pll_off),
      .core_num(core_num), .core_den(core_den), .lock_sts(lock_sts), .cfg_err(cfg_err)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic byp;
      int den;
      byp = (e_mult == 0) || !e_lock || e_off;
      den = (e_div < 2) ? 4 : (e_div == 2) ? 2 : 1;
      chk(tag, "mult_code", mult_code, e_mult);
      chk(tag, "div_sel", div_sel, e_div);
      chk(tag, "pll_off", pll_off, e_off);
      chk(tag, "lock_sts", lock_sts, e_lock);
      chk(tag, "cfg_err", cfg_err, e_err);
      chk(tag, "pll_bypass", pll_bypass, byp);
      chk(tag, "core_num", core_num, byp ? 1 : e_mult);
      chk(tag, "core_den", core_den, den);
   endtask

   // one cycle: drive, model the requirements, clock, compare
   task automatic step(input string tag, input bit we, input bit sel, input logic [3:0] d,
                       input bit pr, input bit lk, input bit srst = 0, input bit hrst = 0);
      bit gate, dw;
      logic [3:0] n_mult; logic [1:0] n_div; logic n_off, n_lock, n_err;
      wr_en = we; wr_sel = sel; wr_data = d; wr_prot = pr; pll_lock = lk;
      dbg_rst = srst; mclk_rst = 0; wdog_rst = hrst; ext_rst_n = 1;
      n_mult = e_mult; n_div = e_div; n_off = e_off; n_lock = e_lock; n_err = e_err;
      if (hrst) begin
         n_mult = 0; n_div = 0; n_off = 0; n_lock = 0; n_err = 0;
      end else begin
         gate = we && pr && !sel && e_div == 0 && !e_off;
         if (gate && d <= 10) n_mult = d;
         if (gate && d <= 10) n_lock = 0;
         else if (e_off) n_lock = 0;
         else if (lk) n_lock = 1;
         if (srst) n_err = 0;
         else if (gate && d > 10) n_err = 1;
         dw = we && pr && sel;
         if (dw && (e_lock || e_off) && (d[1:0] != 3 || e_mult == 0 || e_off)) n_div = d[1:0];
         if (dw) begin
            if (!d[2]) n_off = 0;
            else if (e_mult == 0) n_off = 1;
         end
      end
      @(posedge clk); #2;
      e_mult = n_mult; e_div = n_div; e_off = n_off; e_lock = n_lock; e_err = n_err;
      check_all(tag);
      wr_en = 0;
   endtask

   initial begin
      e_mult = 0; e_div = 0; e_off = 0; e_lock = 0; e_err = 0;
      ext_rst_n = 0; wdog_rst = 0; dbg_rst = 0; mclk_rst = 0;
      wr_en = 0; wr_prot = 0; wr_sel = 0; wr_data = 0; pll_lock = 0;
      repeat (3) @(posedge clk);
      #2;
      check_all("R1");
      step("R6", 0, 0, 0, 0, 1);
      step("R3", 1, 0, 4'd5, 0, 0);
      step("R3", 1, 1, 4'd2, 0, 0);
      // sweep all multiplier codes
      for (int c = 0; c < 16; c++) begin
         step((c > 10) ? "R5" : "R4", 1, 0, 4'(c), 1, 0);
         step("R7", 0, 0, 0, 0, 0);
         step("R6", 0, 0, 0, 0, 1);
         step("R7", 0, 0, 0, 0, 0);
      end
      step("R2", 0, 0, 0, 0, 0, 1);
      step("R4", 1, 0, 4'd5, 1, 0);
      step("R6", 0, 0, 0, 0, 1);
      step("R8", 1, 1, 4'd2, 1, 0);
      step("R4", 1, 0, 4'd3, 1, 0);
      step("R9", 1, 1, 4'd3, 1, 0);
      step("R8", 1, 1, 4'd1, 1, 0);
      step("R8", 1, 1, 4'd0, 1, 0);
      step("R10", 1, 1, 4'd4, 1, 0);
      step("R4", 1, 0, 4'd0, 1, 0);
      step("R8", 1, 1, 4'd3, 1, 0);
      step("R6", 0, 0, 0, 0, 1);
      step("R9", 1, 1, 4'd3, 1, 0);
      step("R4", 1, 0, 4'd6, 1, 1);
      step("R8", 1, 1, 4'd0, 1, 0);
      step("R4", 1, 0, 4'd7, 1, 0);
      step("R8", 1, 1, 4'd2, 1, 0);
      step("R5", 1, 0, 4'd12, 1, 0);
      step("R10", 1, 1, 4'd4, 1, 0);
      step("R4", 1, 0, 4'd0, 1, 0);
      step("R10", 1, 1, 4'd4, 1, 1);
      step("R6", 0, 0, 0, 0, 1);
      step("R4", 1, 0, 4'd3, 1, 0);
      step("R8", 1, 1, 4'd7, 1, 0);
      step("R2", 0, 0, 0, 0, 1, 1);
      step("R10", 1, 1, 4'd3, 1, 0);
      step("R6", 0, 0, 0, 0, 1);
      step("R1", 0, 0, 0, 0, 0, 0, 1);
      step("R1", 0, 0, 0, 0, 1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule